// File: doc/BRIEF.md
# One-Hot Select Right Rotator

This block rotates a data word to the right by an amount that arrives as a one-hot select vector rather than as a binary count. Setting select bit k rotates the word right by k places, so bit i of the result takes data bit (i + k) mod WIDTH. The word width is a parameter and defaults to 4.

Each result bit is modelled as a shared line with one candidate driver per select bit. Only the driver whose select bit is set contributes. In place of tri-state buffers, every line is an AND-OR: each candidate source bit is ANDed with its select bit, and the products are ORed together. The block is purely combinational and has no clock or reset.

Two select patterns fall outside the legal one-hot set, and both have a defined result. An all-zero select gives an all-zero output. A select with several bits set gives the bitwise OR of the rotations those bits name.

Top module: `rotsel_rotator`

## Requirements
- R1: Select bit k set alone (select value 2^k, bit 0 being the least significant) rotates the data right by k places.
- R2: The select value with only bit 0 set passes the data through unchanged.
- R3: For every legal one-hot select value of bit k and every data value, output bit i equals data bit (i + k) mod WIDTH; for WIDTH 4 with select 0010 the output is {x0,x3,x2,x1}.
- R4: An all-zero select drives the output to all zeros, whatever the data.
- R5: A select with two or more bits set yields the bitwise OR of the rotations named by each set bit.
- R6: The output follows a change of data or select with no clock edge; it is combinational.
- R7: For a legal one-hot select the output has the same number of set bits as the data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_i | input | WIDTH | Word to rotate |
| sel_i | input | WIDTH | One-hot rotation amount; bit k requests a right rotation by k |
| rot_o | output | WIDTH | Rotated word |

## Verification
The bench applies every data value under every legal select. This exposes a design whose rotation runs the wrong way or is off by one. Such a design would give a left rotation or a shift by k+1 for some select bit. The bench also drives an all-zero select, which catches a design that falls back to pass-through when no source is enabled. Overlapping selects check the OR of rotations, so a design using a priority pick, or only the lowest set bit, returns a single rotation where two were expected. Inputs are sampled one time step after each change, with no clock edge in between, so any register placed on the path shows up as a stale output.

// File: rtl/rotsel_pkg.sv
package rotsel_pkg;

    localparam int unsigned ROTSEL_MAX_W = 32;

    typedef enum logic [1:0] {
        SEL_NONE   = 2'd0,
        SEL_SINGLE = 2'd1,
        SEL_MULTI  = 2'd2
    } sel_class_e;

    function automatic sel_class_e classify_sel(input logic [ROTSEL_MAX_W-1:0] s);
        int unsigned n;
        n = 0;
        for (int b = 0; b < ROTSEL_MAX_W; b++) begin
            n += int'(s[b]);
        end
        if (n == 0)      return SEL_NONE;
        else if (n == 1) return SEL_SINGLE;
        else             return SEL_MULTI;
    endfunction

endpackage

// File: rtl/rotsel_source_map.sv
module rotsel_source_map #(
    parameter int unsigned WIDTH = 4
) (
    input  logic [WIDTH-1:0]            data_i,
    output logic [WIDTH-1:0][WIDTH-1:0] cand_o
);
    // cand_o[i][k] is the bit that lane i shows when a right rotation by k is picked
    for (genvar i = 0; i < WIDTH; i++) begin : g_lane
        for (genvar k = 0; k < WIDTH; k++) begin : g_amt
            localparam int unsigned SRC = (i + k) % WIDTH;
            assign cand_o[i][k] = data_i[SRC];
        end
    end
endmodule

// File: rtl/rotsel_bus_line.sv
module rotsel_bus_line #(
    parameter int unsigned WIDTH = 4
) (
    input  logic [WIDTH-1:0] cand_i,
    input  logic [WIDTH-1:0] sel_i,
    output logic             line_o
);
    logic [WIDTH-1:0] gated;

    always_comb begin
        gated  = cand_i & sel_i;
        line_o = |gated;
    end

    // R4: a lane with no enabled driver stays low
    always_comb begin
        if (sel_i == '0) begin
            a_r4_idle_line: assert (line_o == 1'b0)
                else $error("lane driven with no select");
        end
    end

    // R5: a high lane needs at least one high candidate
    always_comb begin
        if (line_o) begin
            a_r5_line_has_source: assert (cand_i != '0)
                else $error("lane high with no high source");
        end
    end
endmodule

// File: rtl/rotsel_rotator.sv
module rotsel_rotator
    import rotsel_pkg::*;
#(
    parameter int unsigned WIDTH = 4
) (
    input  logic [WIDTH-1:0] data_i,
    input  logic [WIDTH-1:0] sel_i,
    output logic [WIDTH-1:0] rot_o
);
    logic [WIDTH-1:0][WIDTH-1:0] cand;

    rotsel_source_map #(.WIDTH(WIDTH)) u_map (
        .data_i (data_i),
        .cand_o (cand)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_line
        rotsel_bus_line #(.WIDTH(WIDTH)) u_line (
            .cand_i (cand[i]),
            .sel_i  (sel_i),
            .line_o (rot_o[i])
        );
    end

    // Shift-based reference for the checks below
    logic [WIDTH-1:0] chk_ref;
    sel_class_e       chk_class;

    always_comb begin
        chk_class = classify_sel(ROTSEL_MAX_W'(sel_i));
        chk_ref   = '0;
        for (int k = 0; k < WIDTH; k++) begin
            if (sel_i[k]) begin
                chk_ref = chk_ref | (data_i >> k) | (data_i << (WIDTH - k));
            end
        end
    end

    always_comb begin
        // R1, R3: single select bit k gives right rotation by k
        if (chk_class == SEL_SINGLE) begin
            a_r3_single_rotation: assert (rot_o == chk_ref)
                else $error("rotation mismatch");
            // R7: rotation keeps the population count
            a_r7_popcount_kept: assert ($countones(rot_o) == $countones(data_i))
                else $error("population count changed");
        end
        // R2: bit 0 alone passes data through
        if (sel_i == WIDTH'(1)) begin
            a_r2_identity: assert (rot_o == data_i)
                else $error("identity select altered data");
        end
        // R4: no select, no output
        if (chk_class == SEL_NONE) begin
            a_r4_zero_out: assert (rot_o == '0)
                else $error("output nonzero with empty select");
        end
        // R5: several select bits combine by OR
        if (chk_class == SEL_MULTI) begin
            a_r5_or_of_rotations: assert (rot_o == chk_ref)
                else $error("multi-select OR mismatch");
        end
    end
endmodule

// File: tb/rotsel_rotator_tb.sv
`timescale 1ns/1ps
module rotsel_rotator_tb;
    localparam int W = 4;
    localparam int NVEC = 11;
    localparam int WD_LIMIT = 20000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic [W-1:0] data, sel, rot;
    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit done     = 1'b0;

    rotsel_rotator #(.WIDTH(W)) u_dut (
        .data_i (data),
        .sel_i  (sel),
        .rot_o  (rot)
    );

    // {data, sel, expected}
    localparam logic [3*W-1:0] VEC [NVEC] = '{
        {4'b1011, 4'b0001, 4'b1011},
        {4'b1011, 4'b0010, 4'b1101},
        {4'b1011, 4'b0100, 4'b1110},
        {4'b1011, 4'b1000, 4'b0111},
        {4'b0001, 4'b1000, 4'b0010},
        {4'b1000, 4'b0010, 4'b0100},
        {4'b0110, 4'b0000, 4'b0000},
        {4'b0001, 4'b0011, 4'b1001},
        {4'b0001, 4'b1111, 4'b1111},
        {4'b1010, 4'b0101, 4'b1010},
        {4'b1100, 4'b1010, 4'b1111}
    };

    function automatic logic [W-1:0] ref_rot(input logic [W-1:0] d, input int k);
        logic [W-1:0] r;
        for (int i = 0; i < W; i++) r[i] = d[(i + k) % W];
        return r;
    endfunction

    task automatic check(input string req, input logic [W-1:0] exp);
        n_checks++;
        if (rot !== exp) begin
            n_fail++;
            $display("FAIL %s data=%b sel=%b got=%b expected=%b", req, data, sel, rot, exp);
        end
    endtask

    task automatic apply(input logic [W-1:0] d, input logic [W-1:0] s);
        data = d;
        sel  = s;
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WD_LIMIT) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        data = '0;
        sel  = '0;
        repeat (2) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R4: start-up state, empty select gives zero
        check("R4", 4'b0000);

        // Table walk: R1, R2, R4, R5
        for (int v = 0; v < NVEC; v++) begin
            apply(VEC[v][3*W-1:2*W], VEC[v][2*W-1:W]);
            check("R1/R5 table", VEC[v][W-1:0]);
        end

        // R3, R7: exhaustive data under each legal select
        for (int k = 0; k < W; k++) begin
            for (int d = 0; d < (1 << W); d++) begin
                apply(W'(d), W'(1) << k);
                check("R3", ref_rot(W'(d), k));
                n_checks++;
                if ($countones(rot) != $countones(W'(d))) begin
                    n_fail++;
                    $display("FAIL R7 popcount got=%0d expected=%0d",
                             $countones(rot), $countones(W'(d)));
                end
            end
        end

        // R2: identity on all data
        for (int d = 0; d < (1 << W); d++) begin
            apply(W'(d), 4'b0001);
            check("R2", W'(d));
        end

        // R4: empty select with all-ones data
        apply(4'b1111, 4'b0000);
        check("R4", 4'b0000);

        // R5: every multi-bit select against OR of rotations
        for (int s = 0; s < (1 << W); s++) begin
            if ($countones(W'(s)) >= 2) begin
                logic [W-1:0] exp;
                apply(4'b0010, W'(s));
                exp = '0;
                for (int k = 0; k < W; k++) if (s[k]) exp |= ref_rot(4'b0010, k);
                check("R5", exp);
            end
        end

        // R6: output follows input with no clock edge in between
        @(posedge clk);
        #2;
        apply(4'b0100, 4'b0100);
        check("R6", 4'b0001);
        apply(4'b0100, 4'b0010);
        check("R6", 4'b0010);

        finish_run();
    end
endmodule